// File: doc/BRIEF.md
# Read/Write Turnaround Scheduler

This block sits in front of a single DRAM data bus and decides, one request per cycle, what goes out next. Reads and writes arrive on two separate push ports and are held in two age-ordered queues. Reads own the bus by default. Once the write backlog climbs past a high watermark, the scheduler stops taking reads, idles the bus for a read-to-write turnaround, and then drains writes. It returns to reads after the backlog has fallen to a low watermark and a minimum number of writes has gone out in the current write period. The return trip also idles the bus, this time for the write-to-read gap.

Inside the queue that currently owns the bus, a request is eligible only when its bank reports ready. In the default first-ready mode, an eligible request whose row is already open in its bank is taken before any other eligible request. Otherwise the oldest eligible request is taken. A strict arrival-order mode considers only the head of the queue. A read that arrives while a write to the same burst address is pending is answered from the write queue and never enters the read queue. The read-side capacity includes reads that have been issued but whose data the requester has not yet acknowledged. A request may span several consecutive bursts. It is accepted only when every one of its bursts fits.

Top module: `rw_turn_sched`

## Requirements
- R1: After reset the scheduler is in read mode (mode code 0), both queues are empty, no request is issued, and both full flags and both retry strobes are low.
- R2: With `fcfs_mode` low, only entries whose bank has `bank_rdy` set can issue. A row hit is taken before any non-hit, with the oldest entry winning among hits. Without a hit, the oldest eligible entry is taken. A row hit means `open_vld` is set for the bank and the bank's `open_row` slice equals the row. Address layout: bits [2:0] column, bits [4:3] bank, bits [11:5] row. The `open_row` slice of bank b is bits [b*7 +: 7].
- R3: With `fcfs_mode` high, only the oldest entry of the active queue is considered. If its bank is not ready, nothing issues, even when younger entries could.
- R4: A push with length L (1 to 4) is accepted only when at least L entries are free. It then occupies bursts at addr, addr+1, ... addr+L-1 in that order. A push that does not fit is dropped as a whole.
- R5: Read capacity is the read queue depth minus queued reads minus issued reads still awaiting a `rd_done` pulse.
- R6: `rd_full`/`wr_full` are high exactly when no entry is free. After a push is rejected, the matching retry strobe is high for one cycle once enough entries are free for the rejected length.
- R7: An accepted read burst whose address equals a write queue entry present at the start of the cycle is not queued. `rd_fwd` is high in that cycle, and `rd_fwd_cnt` gives the number of such bursts.
- R8: When the write count at the end of a read-mode cycle exceeds the high watermark (5), the next cycle is in mode 1 (to-write), and no read issues from then on until read mode returns.
- R9: Mode 1 lasts exactly 2 cycles with no issue, and then mode 2 (write) follows. Mode 2 is entered only from mode 1.
- R10: Write mode ends after a cycle in which the write count is at most the low watermark (3) and at least 4 writes have issued since the switch, or the write queue is empty.
- R11: Mode 3 (to-read) follows write mode and lasts exactly 3 cycles with no issue. Read mode is entered only from mode 3.
- R12: `wr_run_cnt` counts writes issued since the last switch towards writes and holds its value afterwards. `rd_run_cnt` counts reads issued since read mode was last entered.
- R13: At most one request issues per cycle, always to a bank with `bank_rdy` set. Writes issue only in mode 2 and reads only in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 selects strict arrival order, 0 selects row-hit first |
| rd_push | input | 1 | Read request strobe |
| rd_addr | input | 12 | Burst address of the first read burst |
| rd_len | input | 3 | Number of read bursts (1 to 4) |
| rd_full | output | 1 | No read entry free |
| rd_retry | output | 1 | Space for the last rejected read has appeared |
| rd_fwd | output | 1 | Part of the pushed read is answered from the write queue |
| rd_fwd_cnt | output | 3 | Number of forwarded bursts this cycle |
| rd_done | input | 1 | One issued read has left the response stage |
| wr_push | input | 1 | Write request strobe |
| wr_addr | input | 12 | Burst address of the first write burst |
| wr_len | input | 3 | Number of write bursts (1 to 4) |
| wr_full | output | 1 | No write entry free |
| wr_retry | output | 1 | Space for the last rejected write has appeared |
| open_vld | input | 4 | Per bank: a row is open |
| open_row | input | 28 | Per bank: the open row, 7 bits per bank |
| bank_rdy | input | 4 | Per bank: may accept a column access now |
| iss_valid | output | 1 | A request issues this cycle |
| iss_write | output | 1 | The issued request is a write |
| iss_addr | output | 12 | Burst address of the issued request |
| mode | output | 2 | 0 read, 1 to-write, 2 write, 3 to-read |
| wr_run_cnt | output | 8 | Writes issued in the current or last write period |
| rd_run_cnt | output | 8 | Reads issued in the current or last read period |

## Verification
The assertions assume a well-behaved environment. `rd_done` pulses only while issued reads are outstanding, push lengths stay between 1 and 4, and `bank_rdy` and the open-row inputs are valid in every cycle. The bench drives every push with a legal length. It pulses `rd_done` only after it has seen reads issue; extra pulses arrive only when the response count is already zero, where they are ignored. It changes the bank and open-row inputs only between clock edges, so each issue decision sees a stable view of the banks.

// File: rtl/rw_turn_sched.sv
`timescale 1ns/1ps
module rw_turn_sched #(
  parameter int ADDR_W   = 12,
  parameter int COL_W    = 3,
  parameter int BANKS    = 4,
  parameter int RQ_DEPTH = 8,
  parameter int WQ_DEPTH = 8,
  parameter int MAX_LEN  = 4,
  parameter int HI_WM    = 5,
  parameter int LO_WM    = 3,
  parameter int MIN_WR   = 4,
  parameter int T_RTW    = 2,
  parameter int T_WTR    = 3,
  parameter int RUN_W    = 8,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int ROW_W   = ADDR_W - COL_W - BANK_W,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fcfs_mode,
  input  logic                    rd_push,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LEN_W-1:0]        rd_len,
  output logic                    rd_full,
  output logic                    rd_retry,
  output logic                    rd_fwd,
  output logic [LEN_W-1:0]        rd_fwd_cnt,
  input  logic                    rd_done,
  input  logic                    wr_push,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LEN_W-1:0]        wr_len,
  output logic                    wr_full,
  output logic                    wr_retry,
  input  logic [BANKS-1:0]        open_vld,
  input  logic [BANKS*ROW_W-1:0]  open_row,
  input  logic [BANKS-1:0]        bank_rdy,
  output logic                    iss_valid,
  output logic                    iss_write,
  output logic [ADDR_W-1:0]       iss_addr,
  output logic [1:0]              mode,
  output logic [RUN_W-1:0]        wr_run_cnt,
  output logic [RUN_W-1:0]        rd_run_cnt
);
  localparam int RC_W = $clog2(RQ_DEPTH + 1);
  localparam int WC_W = $clog2(WQ_DEPTH + 1);
  localparam int RI_W = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1;
  localparam int WI_W = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1;
  localparam int TMAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
  localparam int TM_W = $clog2(TMAX + 1);
  localparam logic [1:0] M_RD = 2'd0, M_TOW = 2'd1, M_WR = 2'd2, M_TOR = 2'd3;

  logic [ADDR_W-1:0] rq [RQ_DEPTH];
  logic [ADDR_W-1:0] wq [WQ_DEPTH];
  logic [ADDR_W-1:0] rq_n [RQ_DEPTH];
  logic [ADDR_W-1:0] wq_n [WQ_DEPTH];
  logic [RC_W-1:0]   rq_cnt, rq_cnt_n, rsp_cnt, rd_free;
  logic [WC_W-1:0]   wq_cnt, wq_cnt_n, wr_free;
  logic [TM_W-1:0]   tmr;
  logic              rd_ok, wr_ok, rd_rej, wr_rej;
  logic [LEN_W-1:0]  rd_rej_len, wr_rej_len;
  logic [MAX_LEN-1:0] fwd_hit;
  logic              r_found, w_found, rd_go, wr_go;
  logic [RI_W-1:0]   r_idx;
  logic [WI_W-1:0]   w_idx;
  logic [RUN_W-1:0]  wrun_n;

  assign rd_free = RC_W'(RQ_DEPTH) - rq_cnt - rsp_cnt;
  assign wr_free = WC_W'(WQ_DEPTH) - wq_cnt;
  assign rd_full = (rd_free == '0);
  assign wr_full = (wr_free == '0);
  assign rd_ok = rd_push && (rd_len != '0) && (int'(rd_len) <= MAX_LEN) &&
                 (int'(rd_len) <= int'(rd_free));
  assign wr_ok = wr_push && (wr_len != '0) && (int'(wr_len) <= MAX_LEN) &&
                 (int'(wr_len) <= int'(wr_free));
  assign rd_retry = rd_rej && (int'(rd_free) >= int'(rd_rej_len));
  assign wr_retry = wr_rej && (int'(wr_free) >= int'(wr_rej_len));

  always_comb begin
    fwd_hit = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      for (int j = 0; j < WQ_DEPTH; j++) begin
        if (k < int'(rd_len) && j < int'(wq_cnt) && wq[j] == rd_addr + ADDR_W'(k))
          fwd_hit[k] = 1'b1;
      end
    end
  end

  always_comb begin
    rd_fwd_cnt = '0;
    for (int k = 0; k < MAX_LEN; k++)
      if (rd_ok && fwd_hit[k]) rd_fwd_cnt = rd_fwd_cnt + LEN_W'(1);
  end
  assign rd_fwd = (rd_fwd_cnt != '0);

  always_comb begin
    logic [BANK_W-1:0] b;
    logic hit, hit_seen;
    r_found = 1'b0;
    r_idx = '0;
    hit_seen = 1'b0;
    for (int i = 0; i < RQ_DEPTH; i++) begin
      b = rq[i][COL_W +: BANK_W];
      hit = open_vld[b] && (open_row[int'(b)*ROW_W +: ROW_W] == rq[i][ADDR_W-1 -: ROW_W]);
      if (i < int'(rq_cnt)) begin
        if (fcfs_mode) begin
          if (i == 0) r_found = bank_rdy[b];
        end else if (bank_rdy[b] && hit && !hit_seen) begin
          r_found = 1'b1;
          hit_seen = 1'b1;
          r_idx = RI_W'(i);
        end else if (bank_rdy[b] && !r_found) begin
          r_found = 1'b1;
          r_idx = RI_W'(i);
        end
      end
    end
  end

  always_comb begin
    logic [BANK_W-1:0] b;
    logic hit, hit_seen;
    w_found = 1'b0;
    w_idx = '0;
    hit_seen = 1'b0;
    for (int i = 0; i < WQ_DEPTH; i++) begin
      b = wq[i][COL_W +: BANK_W];
      hit = open_vld[b] && (open_row[int'(b)*ROW_W +: ROW_W] == wq[i][ADDR_W-1 -: ROW_W]);
      if (i < int'(wq_cnt)) begin
        if (fcfs_mode) begin
          if (i == 0) w_found = bank_rdy[b];
        end else if (bank_rdy[b] && hit && !hit_seen) begin
          w_found = 1'b1;
          hit_seen = 1'b1;
          w_idx = WI_W'(i);
        end else if (bank_rdy[b] && !w_found) begin
          w_found = 1'b1;
          w_idx = WI_W'(i);
        end
      end
    end
  end

  assign rd_go     = (mode == M_RD) && r_found;
  assign wr_go     = (mode == M_WR) && w_found;
  assign iss_valid = rd_go || wr_go;
  assign iss_write = wr_go;
  assign iss_addr  = wr_go ? wq[w_idx] : rq[r_idx];

  always_comb begin
    rq_n = rq;
    rq_cnt_n = rq_cnt;
    if (rd_go) begin
      for (int i = 0; i < RQ_DEPTH - 1; i++)
        if (i >= int'(r_idx)) rq_n[i] = rq[i+1];
      rq_cnt_n = rq_cnt_n - RC_W'(1);
    end
    for (int k = 0; k < MAX_LEN; k++) begin
      if (rd_ok && k < int'(rd_len) && !fwd_hit[k]) begin
        if (int'(rq_cnt_n) < RQ_DEPTH) rq_n[RI_W'(rq_cnt_n)] = rd_addr + ADDR_W'(k);
        rq_cnt_n = rq_cnt_n + RC_W'(1);
      end
    end
  end

  always_comb begin
    wq_n = wq;
    wq_cnt_n = wq_cnt;
    if (wr_go) begin
      for (int i = 0; i < WQ_DEPTH - 1; i++)
        if (i >= int'(w_idx)) wq_n[i] = wq[i+1];
      wq_cnt_n = wq_cnt_n - WC_W'(1);
    end
    for (int k = 0; k < MAX_LEN; k++) begin
      if (wr_ok && k < int'(wr_len)) begin
        if (int'(wq_cnt_n) < WQ_DEPTH) wq_n[WI_W'(wq_cnt_n)] = wr_addr + ADDR_W'(k);
        wq_cnt_n = wq_cnt_n + WC_W'(1);
      end
    end
  end

  assign wrun_n = (wr_go && wr_run_cnt != '1) ? wr_run_cnt + RUN_W'(1) : wr_run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RQ_DEPTH; i++) rq[i] <= '0;
      for (int i = 0; i < WQ_DEPTH; i++) wq[i] <= '0;
      rq_cnt <= '0;
      wq_cnt <= '0;
      rsp_cnt <= '0;
    end else begin
      rq <= rq_n;
      wq <= wq_n;
      rq_cnt <= rq_cnt_n;
      wq_cnt <= wq_cnt_n;
      rsp_cnt <= rsp_cnt + RC_W'(rd_go) - RC_W'(rd_done && rsp_cnt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rej <= 1'b0;
      rd_rej_len <= '0;
      wr_rej <= 1'b0;
      wr_rej_len <= '0;
    end else begin
      if (rd_push && !rd_ok) begin
        rd_rej <= 1'b1;
        rd_rej_len <= rd_len;
      end else if (rd_retry) rd_rej <= 1'b0;
      if (wr_push && !wr_ok) begin
        wr_rej <= 1'b1;
        wr_rej_len <= wr_len;
      end else if (wr_retry) wr_rej <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_RD;
      tmr <= '0;
      wr_run_cnt <= '0;
      rd_run_cnt <= '0;
    end else begin
      case (mode)
        M_RD: begin
          if (rd_go && rd_run_cnt != '1) rd_run_cnt <= rd_run_cnt + RUN_W'(1);
          if (int'(wq_cnt_n) > HI_WM) begin
            mode <= M_TOW;
            tmr <= TM_W'(T_RTW - 1);
            wr_run_cnt <= '0;
          end
        end
        M_TOW: begin
          if (tmr == '0) mode <= M_WR;
          else tmr <= tmr - TM_W'(1);
        end
        M_WR: begin
          wr_run_cnt <= wrun_n;
          if ((int'(wq_cnt_n) <= LO_WM && int'(wrun_n) >= MIN_WR) || wq_cnt_n == '0) begin
            mode <= M_TOR;
            tmr <= TM_W'(T_WTR - 1);
          end
        end
        default: begin
          if (tmr == '0) begin
            mode <= M_RD;
            rd_run_cnt <= '0;
          end else tmr <= tmr - TM_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/rw_turn_sched_chk.sv
`timescale 1ns/1ps
module rw_turn_sched_chk #(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 3,
  parameter int BANKS  = 4,
  parameter int WC_W   = 4,
  parameter int LO_WM  = 3,
  parameter int MIN_WR = 4,
  parameter int RUN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              iss_valid,
  input logic              iss_write,
  input logic [ADDR_W-1:0] iss_addr,
  input logic [BANKS-1:0]  bank_rdy,
  input logic [RUN_W-1:0]  wr_run_cnt,
  input logic [WC_W-1:0]   wq_cnt,
  input logic              rd_push,
  input logic              rd_fwd
);
  localparam int BANK_W = $clog2(BANKS);

  AST_ISSUE_BANK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> bank_rdy[iss_addr[COL_W +: BANK_W]]); // R13
  AST_KIND_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((mode == 2'd2) == iss_write)); // R13
  AST_QUIET_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd3) |-> !iss_valid); // R9
  AST_WRITE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1); // R9
  AST_READ_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) != 2'd0) |-> $past(mode) == 2'd3); // R11
  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) == 2'd2) |->
      ((int'(wq_cnt) <= LO_WM && int'(wr_run_cnt) >= MIN_WR) || wq_cnt == '0)); // R10
  AST_FWD_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> rd_push); // R7
endmodule

bind rw_turn_sched rw_turn_sched_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .BANKS(BANKS), .WC_W(WC_W),
  .LO_WM(LO_WM), .MIN_WR(MIN_WR), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .iss_valid(iss_valid),
  .iss_write(iss_write), .iss_addr(iss_addr), .bank_rdy(bank_rdy),
  .wr_run_cnt(wr_run_cnt), .wq_cnt(wq_cnt), .rd_push(rd_push), .rd_fwd(rd_fwd)
);

// File: tb/rw_turn_sched_bench.sv
`timescale 1ns/1ps
module rw_turn_sched_bench;
  logic        clk = 1'b0, rst_n = 1'b0, fcfs_mode = 1'b0;
  logic        rd_push = 1'b0, rd_done = 1'b0, wr_push = 1'b0;
  logic [11:0] rd_addr = '0, wr_addr = '0;
  logic [2:0]  rd_len = 3'd1, wr_len = 3'd1;
  logic [3:0]  open_vld = '0, bank_rdy = '0;
  logic [27:0] open_row = '0;
  logic        rd_full, rd_retry, rd_fwd, wr_full, wr_retry, iss_valid, iss_write;
  logic [2:0]  rd_fwd_cnt;
  logic [11:0] iss_addr;
  logic [1:0]  mode;
  logic [7:0]  wr_run_cnt, rd_run_cnt;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rw_turn_sched u_rw_turn_sched (
    .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode),
    .rd_push(rd_push), .rd_addr(rd_addr), .rd_len(rd_len), .rd_full(rd_full),
    .rd_retry(rd_retry), .rd_fwd(rd_fwd), .rd_fwd_cnt(rd_fwd_cnt), .rd_done(rd_done),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_len(wr_len), .wr_full(wr_full),
    .wr_retry(wr_retry), .open_vld(open_vld), .open_row(open_row), .bank_rdy(bank_rdy),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr), .mode(mode),
    .wr_run_cnt(wr_run_cnt), .rd_run_cnt(rd_run_cnt)
  );

  function automatic logic [11:0] mk(input int row, input int bank, input int col);
    return {7'(row), 2'(bank), 3'(col)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #4;
  endtask

  task automatic push_rd(input logic [11:0] a, input int len);
    rd_push = 1'b1; rd_addr = a; rd_len = 3'(len);
    cyc();
    rd_push = 1'b0;
  endtask

  task automatic push_wr(input logic [11:0] a, input int len);
    wr_push = 1'b1; wr_addr = a; wr_len = 3'(len);
    cyc();
    wr_push = 1'b0;
  endtask

  task automatic drain_rsp();
    rd_done = 1'b1;
    repeat (8) cyc();
    rd_done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(!iss_valid, "R1 issue", iss_valid, 0);
    chk(!rd_full && !wr_full, "R1 full flags", {rd_full, wr_full}, 0);
    chk(!rd_retry && !wr_retry, "R1 retry", {rd_retry, wr_retry}, 0);
  endtask

  task automatic t_frfcfs();
    fcfs_mode = 1'b0; bank_rdy = '0;
    push_rd(mk(1, 0, 0), 1);
    push_rd(mk(2, 0, 0), 1);
    push_rd(mk(5, 1, 0), 1);
    open_vld = 4'b0001; open_row[6:0] = 7'd2;
    #1;
    chk(!iss_valid, "R13 no ready bank", iss_valid, 0);
    bank_rdy = 4'b0010; #1;
    chk(iss_valid && iss_addr == mk(5, 1, 0), "R2 oldest ready", iss_addr, mk(5, 1, 0));
    bank_rdy = 4'b0001; #1;
    chk(iss_valid && iss_addr == mk(2, 0, 0), "R2 row hit first", iss_addr, mk(2, 0, 0));
    cyc(); #1;
    chk(iss_valid && iss_addr == mk(1, 0, 0), "R2 next oldest", iss_addr, mk(1, 0, 0));
    cyc();
    bank_rdy = 4'b0010; #1;
    chk(iss_valid && iss_addr == mk(5, 1, 0), "R2 last entry", iss_addr, mk(5, 1, 0));
    cyc();
    bank_rdy = '0; open_vld = '0;
    drain_rsp();
  endtask

  task automatic t_fcfs();
    fcfs_mode = 1'b1;
    push_rd(mk(1, 0, 0), 1);
    push_rd(mk(2, 1, 0), 1);
    open_vld = 4'b0010; open_row[13:7] = 7'd2;
    bank_rdy = 4'b0010; #1;
    chk(!iss_valid, "R3 head bank blocks", iss_valid, 0);
    bank_rdy = 4'b0011; #1;
    chk(iss_valid && iss_addr == mk(1, 0, 0), "R3 head first", iss_addr, mk(1, 0, 0));
    cyc(); #1;
    chk(iss_valid && iss_addr == mk(2, 1, 0), "R3 then next", iss_addr, mk(2, 1, 0));
    cyc();
    bank_rdy = '0; open_vld = '0; fcfs_mode = 1'b0;
    drain_rsp();
  endtask

  task automatic t_fwd();
    push_wr(mk(3, 2, 1), 1);
    rd_push = 1'b1; rd_addr = mk(3, 2, 0); rd_len = 3'd2; #1;
    chk(rd_fwd && rd_fwd_cnt == 3'd1, "R7 forward count", rd_fwd_cnt, 1);
    cyc();
    rd_push = 1'b0;
    bank_rdy = 4'b1111; #1;
    chk(iss_valid && !iss_write && iss_addr == mk(3, 2, 0), "R7 unmatched burst queued", iss_addr, mk(3, 2, 0));
    cyc(); #1;
    chk(!iss_valid, "R7 matched burst not queued", iss_valid, 0);
    bank_rdy = '0;
    drain_rsp();
  endtask

  task automatic t_cap();
    int n;
    push_rd(mk(0, 3, 0), 4);
    push_rd(mk(1, 3, 0), 3);
    rd_push = 1'b1; rd_addr = mk(2, 3, 0); rd_len = 3'd3;
    cyc();
    rd_push = 1'b0; #1;
    chk(!rd_full && !rd_retry, "R4 oversize rejected, no retry yet", {rd_full, rd_retry}, 0);
    push_rd(mk(2, 3, 0), 1); #1;
    chk(rd_full, "R6 read full", rd_full, 1);
    bank_rdy = 4'b1000; #1;
    chk(iss_valid && iss_addr == mk(0, 3, 0), "R4 first burst", iss_addr, mk(0, 3, 0));
    cyc(); bank_rdy = '0; #1;
    chk(rd_full, "R5 response stage counted", rd_full, 1);
    bank_rdy = 4'b1000; #1;
    chk(iss_valid && iss_addr == mk(0, 3, 1), "R4 consecutive burst", iss_addr, mk(0, 3, 1));
    cyc(); bank_rdy = '0;
    rd_done = 1'b1; cyc(); rd_done = 1'b0; #1;
    chk(!rd_full && !rd_retry, "R6 free but short of rejected length", {rd_full, rd_retry}, 0);
    rd_done = 1'b1; cyc(); rd_done = 1'b0; #1;
    chk(!rd_retry, "R6 two free", rd_retry, 0);
    bank_rdy = 4'b1000; cyc(); bank_rdy = '0;
    rd_done = 1'b1; cyc(); rd_done = 1'b0; #1;
    chk(rd_retry, "R6 retry raised", rd_retry, 1);
    cyc(); #1;
    chk(!rd_retry, "R6 retry single cycle", rd_retry, 0);
    bank_rdy = 4'b1111; rd_done = 1'b1; n = 0;
    for (int i = 0; i < 12; i++) begin
      #1; if (iss_valid) n++;
      cyc();
    end
    chk(n == 5, "R4 rejected push left no entries", n, 5);
    bank_rdy = '0;
    drain_rsp();
  endtask

  task automatic t_drain();
    int n, g;
    push_rd(mk(6, 0, 0), 1);
    for (int k = 0; k < 4; k++) push_wr(mk(7, 1, k), 1);
    #1;
    chk(mode == 2'd0, "R8 at watermark stays read", mode, 0);
    push_wr(mk(7, 1, 4), 1); #1;
    chk(mode == 2'd1, "R8 above watermark", mode, 1);
    bank_rdy = 4'b1111; #1;
    chk(!iss_valid, "R8 read blocked", iss_valid, 0);
    cyc(); #1;
    chk(mode == 2'd1 && !iss_valid, "R9 second turnaround cycle", mode, 1);
    cyc(); #1;
    chk(mode == 2'd2 && wr_run_cnt == 0, "R9 write mode", mode, 2);
    n = 0; g = 0;
    while (mode == 2'd2 && g < 20) begin
      if (iss_valid && iss_write) n++;
      cyc(); #1; g++;
    end
    chk(n == 4, "R10 writes per switch", n, 4);
    chk(wr_run_cnt == 8'd4, "R12 write run count", wr_run_cnt, 4);
    n = 0; g = 0;
    while (mode == 2'd3 && g < 20) begin
      if (iss_valid) chk(0, "R11 issue during turnaround", 1, 0);
      n++;
      cyc(); #1; g++;
    end
    chk(n == 3, "R11 turnaround length", n, 3);
    chk(mode == 2'd0 && iss_valid && !iss_write && iss_addr == mk(6, 0, 0),
        "R11 read resumes", iss_addr, mk(6, 0, 0));
    chk(rd_run_cnt == 0, "R12 read run reset", rd_run_cnt, 0);
    cyc(); #1;
    chk(rd_run_cnt == 8'd1, "R12 read run count", rd_run_cnt, 1);
    bank_rdy = '0;
    drain_rsp();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    t_reset();
    t_frfcfs();
    t_fcfs();
    t_fwd();
    t_cap();
    t_drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule